// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transmitter

This block turns parallel audio words into a serial bit stream. An external bit clock and frame sync set the timing. The block samples both on its own system clock and acts only on the transmit edge of the bit clock. That edge is the falling edge in normal polarity and the rising edge when the bit clock is inverted.

A frame holds one phase, or two phases back to back, and each phase has its own word count and word length. Stereo in I2S or left-justified form uses two phases of one word each. Every other layout uses a single phase with one word per channel, from 1 up to 16 channels. A programmable delay of zero or one bit slot separates the frame sync from the first data bit.

Words come in through a valid/ready port, one word at the start of each word slot. A missing word produces silence and a sticky underrun flag. A frame sync that arrives in the middle of a frame restarts framing and raises a sticky frame-sync error flag. One clear input resets both flags.

Top module: `dual_phase_ser_tx`

## Requirements
- R1: The word length of each phase is taken from a 3-bit code: 0 selects 8 bits, 1 selects 12, 2 selects 16, 3 selects 20, 4 selects 24 and 5 selects 32. The word sits right-justified in `in_data`, and its most significant bit is sent first.
- R2: In single-phase mode (`cfg_dual`=0) a frame carries `cfg_len1`+1 words of the phase-1 length. Every transmit slot after the last word, up to the next frame start, drives `sd` low, and `sd` is low after reset.
- R3: In dual-phase mode (`cfg_dual`=1) the `cfg_len1`+1 words of phase 1, each of length code `cfg_wl1`, are followed directly by the `cfg_len2`+1 words of phase 2, each of length code `cfg_wl2`.
- R4: With `cfg_dly`=0 the first bit of the first word goes out at the transmit edge where the frame start is seen. With `cfg_dly`=1 that edge drives a low delay slot, and the first bit goes out one transmit edge later.
- R5: The transmit edge is the falling edge of `bclk` when `cfg_bclk_inv`=0 and the rising edge when it is 1. `sd` changes only in the clock cycle right after a transmit edge and holds its value across the other edge.
- R6: A frame starts at a transmit edge where `fsync` is high and was low at the previous transmit edge. Holding `fsync` high over several bit slots starts only one frame.
- R7: `in_ready` is high for one clock cycle at the start of each word slot. A word is consumed only when `in_valid` is high in that cycle.
- R8: If `in_valid` is low when a word slot starts, that word is sent as all zeros and `underrun` is set and stays set.
- R9: A frame start seen while a frame or its delay slot is still in progress restarts the frame from phase 1, word 0, and sets the sticky `fs_err` flag. A normal frame start never sets it.
- R10: A one-cycle pulse on `flag_clr` clears `underrun` and `fs_err`. If a flag is set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dual | input | 1 | Selects dual-phase frames |
| cfg_dly | input | 1 | Data delay of one bit slot after frame start |
| cfg_bclk_inv | input | 1 | Transmit on the rising bit-clock edge instead of the falling edge |
| cfg_len1 | input | 7 | Phase-1 word count minus one |
| cfg_len2 | input | 7 | Phase-2 word count minus one |
| cfg_wl1 | input | 3 | Phase-1 word-length code |
| cfg_wl2 | input | 3 | Phase-2 word-length code |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word slot starting; word taken if valid |
| in_data | input | 32 | Audio word, right-justified |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame sync, active high |
| sd | output | 1 | Serial data out |
| underrun | output | 1 | Sticky missing-word flag |
| fs_err | output | 1 | Sticky mid-frame frame-sync flag |
| flag_clr | input | 1 | Clears both sticky flags |

## Verification
The bench targets the edges of framing:
- The one-slot delay: a wrong delay shifts every bit by one slot.
- The hand-over from phase 1 to phase 2 when the two word lengths differ: a wrong hand-over truncates or pads the second word.
- The widest frame of sixteen 32-bit words: a counter that is too narrow wraps there.
- A frame sync held high over several slots: a level-sensitive start would restart the frame again and again.
- A mid-frame restart: it must both resynchronise and flag.
- Inverted bit-clock polarity: a shifter on the wrong edge changes `sd` across the idle edge.

An underrun must produce silence without consuming a word, and the flag must survive a later good frame until it is cleared.

// File: rtl/dpst_pkg.sv
package dpst_pkg;

    localparam int FLEN_W = 7;   // per-phase word count field
    localparam int WLC_W  = 3;   // word-length code field
    localparam int BCNT_W = 6;   // bit counter, holds up to 32

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_DATA
    } seq_state_e;

    typedef struct packed {
        logic              dual;
        logic              dly;
        logic [FLEN_W-1:0] len1;
        logic [FLEN_W-1:0] len2;
        logic [WLC_W-1:0]  wl1;
        logic [WLC_W-1:0]  wl2;
    } frame_cfg_t;

    function automatic logic [BCNT_W-1:0] wl_bits(input logic [WLC_W-1:0] code);
        case (code)
            3'd0:    return BCNT_W'(8);
            3'd1:    return BCNT_W'(12);
            3'd2:    return BCNT_W'(16);
            3'd3:    return BCNT_W'(20);
            3'd4:    return BCNT_W'(24);
            default: return BCNT_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/dpst_edge.sv
module dpst_edge (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fsync,
    input  logic inv,
    output logic tick,
    output logic fs_start
);
    logic bclk_q;
    logic fs_last;

    always_ff @(posedge clk) begin
        bclk_q <= bclk;
    end

    assign tick     = inv ? (bclk & ~bclk_q) : (~bclk & bclk_q);
    assign fs_start = tick & fsync & ~fs_last;

    always_ff @(posedge clk) begin
        if (rst)       fs_last <= 1'b0;
        else if (tick) fs_last <= fsync;
    end
endmodule

// File: rtl/dpst_seq.sv
module dpst_seq
    import dpst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              fs_start,
    input  frame_cfg_t        cfg,
    output logic              word_start,
    output logic              shift_en,
    output logic [BCNT_W-1:0] wl_now,
    output logic              restart
);
    seq_state_e        st;
    logic              phase;
    logic [FLEN_W-1:0] wcnt;
    logic [BCNT_W-1:0] bcnt;

    logic word_done, last_in_phase, more, nphase;

    always_comb begin
        word_done     = (st == ST_DATA) && (bcnt == '0);
        last_in_phase = (wcnt == (phase ? cfg.len2 : cfg.len1));
        more          = !last_in_phase || (!phase && cfg.dual);
        word_start    = tick && ((fs_start && !cfg.dly) ||
                                 (!fs_start && st == ST_DELAY) ||
                                 (!fs_start && word_done && more));
        if (fs_start || st == ST_DELAY) nphase = 1'b0;
        else if (!last_in_phase)        nphase = phase;
        else                            nphase = 1'b1;
        wl_now   = wl_bits(nphase ? cfg.wl2 : cfg.wl1);
        shift_en = tick && !fs_start && (st == ST_DATA) && (bcnt != '0);
        restart  = fs_start && (st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            phase <= 1'b0;
            wcnt  <= '0;
            bcnt  <= '0;
        end else if (tick) begin
            if (fs_start) begin
                phase <= 1'b0;
                wcnt  <= '0;
                st    <= cfg.dly ? ST_DELAY : ST_DATA;
                bcnt  <= wl_now - 1'b1;
            end else begin
                case (st)
                    ST_DELAY: begin
                        st   <= ST_DATA;
                        bcnt <= wl_now - 1'b1;
                    end
                    ST_DATA: begin
                        if (bcnt != '0) begin
                            bcnt <= bcnt - 1'b1;
                        end else if (more) begin
                            wcnt  <= (nphase != phase) ? '0 : wcnt + 1'b1;
                            phase <= nphase;
                            bcnt  <= wl_now - 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dpst_shift.sv
module dpst_shift
    import dpst_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic              shift,
    input  logic [W-1:0]      data,
    input  logic [BCNT_W-1:0] wl,
    output logic              sd
);
    logic [W-1:0] sr;
    logic [W-1:0] aligned;

    assign aligned = data << (W - int'(wl));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
            sd <= 1'b0;
        end else if (tick) begin
            if (load) begin
                sd <= aligned[W-1];
                sr <= aligned << 1;
            end else if (shift) begin
                sd <= sr[W-1];
                sr <= sr << 1;
            end else begin
                sd <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_phase_ser_tx.sv
module dual_phase_ser_tx
    import dpst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dual,
    input  logic              cfg_dly,
    input  logic              cfg_bclk_inv,
    input  logic [FLEN_W-1:0] cfg_len1,
    input  logic [FLEN_W-1:0] cfg_len2,
    input  logic [WLC_W-1:0]  cfg_wl1,
    input  logic [WLC_W-1:0]  cfg_wl2,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              bclk,
    input  logic              fsync,
    output logic              sd,
    output logic              underrun,
    output logic              fs_err,
    input  logic              flag_clr
);
    frame_cfg_t        cfg;
    logic              tick, fs_start, word_start, shift_en, restart;
    logic [BCNT_W-1:0] wl_now;
    logic [DATA_W-1:0] picked;

    assign cfg = '{dual: cfg_dual, dly: cfg_dly, len1: cfg_len1, len2: cfg_len2,
                   wl1: cfg_wl1, wl2: cfg_wl2};

    dpst_edge u_edge (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .inv(cfg_bclk_inv),
        .tick(tick), .fs_start(fs_start)
    );

    dpst_seq u_seq (
        .clk(clk), .rst(rst), .tick(tick), .fs_start(fs_start), .cfg(cfg),
        .word_start(word_start), .shift_en(shift_en), .wl_now(wl_now),
        .restart(restart)
    );

    assign picked = in_valid ? in_data : '0;

    dpst_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .tick(tick), .load(word_start), .shift(shift_en),
        .data(picked), .wl(wl_now), .sd(sd)
    );

    assign in_ready = word_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            underrun <= 1'b0;
            fs_err   <= 1'b0;
        end else begin
            if (word_start && !in_valid) underrun <= 1'b1;
            else if (flag_clr)           underrun <= 1'b0;
            if (restart)                 fs_err   <= 1'b1;
            else if (flag_clr)           fs_err   <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_phase_ser_tx_chk.sv
module dual_phase_ser_tx_chk (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic sd,
    input logic in_ready,
    input logic in_valid,
    input logic underrun,
    input logic fs_err,
    input logic flag_clr
);
    // R5
    sd_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        (bclk == $past(bclk)) |=> $stable(sd));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    // R8
    underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> underrun);

    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (underrun && !flag_clr) |=> underrun);

    // R9
    fs_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fs_err && !flag_clr) |=> fs_err);

    // R7
    ready_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (bclk != $past(bclk)));
endmodule

bind dual_phase_ser_tx dual_phase_ser_tx_chk u_chk (
    .clk(clk), .rst(rst), .bclk(bclk), .sd(sd), .in_ready(in_ready),
    .in_valid(in_valid), .underrun(underrun), .fs_err(fs_err),
    .flag_clr(flag_clr)
);

// File: tb/dual_phase_ser_tx_bench.sv
module dual_phase_ser_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dual = 0, cfg_dly = 0, cfg_bclk_inv = 0;
    logic [6:0]  cfg_len1 = 0, cfg_len2 = 0;
    logic [2:0]  cfg_wl1 = 0, cfg_wl2 = 0;
    logic        in_valid = 1'b1;
    logic        in_ready;
    logic [31:0] in_data;
    logic        bclk = 1'b0, fsync = 1'b0;
    logic        sd, underrun, fs_err;
    logic        flag_clr = 1'b0;

    logic [31:0] pool [256];
    logic [7:0]  wptr;
    int          n_chk = 0, n_fail = 0;
    bit          prev_sd = 0;

    always #2 clk = ~clk;

    dual_phase_ser_tx u_dual_phase_ser_tx (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_dly(cfg_dly),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_len1(cfg_len1), .cfg_len2(cfg_len2),
        .cfg_wl1(cfg_wl1), .cfg_wl2(cfg_wl2), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .bclk(bclk), .fsync(fsync),
        .sd(sd), .underrun(underrun), .fs_err(fs_err), .flag_clr(flag_clr)
    );

    always @(posedge clk) begin
        if (rst) wptr <= 8'd0;
        else if (in_valid && in_ready) wptr <= wptr + 8'd1;
    end
    assign in_data = pool[wptr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wlb(input int code);
        case (code)
            0: return 8;
            1: return 12;
            2: return 16;
            3: return 20;
            4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic slot(input bit fs, output bit got, output bit stable_ok);
        bit act;
        act = cfg_bclk_inv;
        @(negedge clk);
        bclk = !act;
        repeat (2) @(negedge clk);
        stable_ok = (sd == prev_sd);
        bclk  = act;
        fsync = fs;
        @(negedge clk);
        got     = sd;
        prev_sd = sd;
        @(negedge clk);
    endtask

    task automatic run_frame(input int fs_hold, input bit valid, input string tag);
        bit   e [1100];
        int   n, k, base, mism, unst, first, total;
        bit   got, st;
        logic [31:0] w;
        n = 0; k = 0; mism = 0; unst = 0; first = -1;
        base = int'(wptr);
        if (cfg_dly) begin e[n] = 0; n++; end
        for (int ph = 0; ph < (cfg_dual ? 2 : 1); ph++) begin
            int len, wl;
            len = ph ? int'(cfg_len2) : int'(cfg_len1);
            wl  = wlb(ph ? int'(cfg_wl2) : int'(cfg_wl1));
            for (int i = 0; i <= len; i++) begin
                w = valid ? pool[(base + k) & 255] : 32'd0;
                k++;
                for (int b = wl - 1; b >= 0; b--) begin e[n] = w[b]; n++; end
            end
        end
        total = n + 3;
        for (int s = n; s < total; s++) e[s] = 0;
        in_valid = valid;
        for (int s = 0; s < total; s++) begin
            slot(s < fs_hold, got, st);
            if (got != e[s]) begin
                mism++;
                if (first < 0) first = s;
            end
            if (!st) unst++;
        end
        fsync = 0;
        in_valid = 1'b1;
        check(mism == 0, {tag, " serial bits (mismatch count / first slot)"}, mism, 0);
        if (mism != 0) $display("  first bad slot %0d", first);
        check(((int'(wptr) - base) & 255) == (valid ? k : 0), "R7 words consumed",
              (int'(wptr) - base) & 255, valid ? k : 0);
        check(unst == 0, "R5 sd stable across idle edge", unst, 0);
    endtask

    task automatic set_cfg(input bit dual, input bit dly, input bit inv,
                           input int l1, input int l2, input int w1, input int w2);
        cfg_dual = dual; cfg_dly = dly; cfg_bclk_inv = inv;
        cfg_len1 = 7'(l1); cfg_len2 = 7'(l2);
        cfg_wl1 = 3'(w1);  cfg_wl2 = 3'(w2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit g, s2;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 256; i++) pool[i] = $urandom;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: R2 (sd low), R7, R8, R9
        check(sd == 0, "R2 reset sd", sd, 0);
        check(in_ready == 0, "R7 reset in_ready", in_ready, 0);
        check(underrun == 0, "R8 reset underrun", underrun, 0);
        check(fs_err == 0, "R9 reset fs_err", fs_err, 0);

        // R2 R4: single phase, two 16-bit words, one-slot delay
        set_cfg(0, 1, 0, 1, 0, 2, 2);
        run_frame(1, 1, "R4 R2 single dly1");
        // R3: stereo dual phase, delay 1
        set_cfg(1, 1, 0, 0, 0, 2, 2);
        run_frame(1, 1, "R3 dual dly1");
        // R3 R1: dual phase, 32-bit then 8-bit, no delay
        set_cfg(1, 0, 0, 0, 0, 5, 0);
        run_frame(1, 1, "R3 R1 dual mixed lengths");
        // R5: inverted bit clock
        set_cfg(0, 0, 1, 2, 0, 1, 0);
        run_frame(1, 1, "R5 inverted bclk");
        // R2: sixteen 32-bit channels
        set_cfg(0, 0, 0, 15, 0, 5, 0);
        run_frame(1, 1, "R2 sixteen channels");
        // R6: frame sync held high for several slots
        set_cfg(0, 1, 0, 0, 0, 3, 0);
        run_frame(6, 1, "R6 held fsync");
        check(fs_err == 0, "R9 no false fs_err", fs_err, 0);

        // R1: random configurations
        for (int f = 0; f < 10; f++) begin
            bit dual;
            dual = 1'($urandom);
            set_cfg(dual, 1'($urandom), 1'($urandom),
                    dual ? int'($urandom % 2) : int'($urandom % 4),
                    int'($urandom % 2), int'($urandom % 6), int'($urandom % 6));
            run_frame(1 + int'($urandom % 2), 1, "R1 random frame");
        end
        check(underrun == 0, "R8 no false underrun", underrun, 0);

        // R8: underrun sends zeros and latches the flag
        set_cfg(0, 0, 0, 1, 0, 2, 0);
        run_frame(1, 0, "R8 underrun zeros");
        check(underrun == 1, "R8 underrun set", underrun, 1);
        run_frame(1, 1, "R8 good frame after underrun");
        check(underrun == 1, "R8 underrun sticky", underrun, 1);
        // R10: clear
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check(underrun == 0, "R10 underrun cleared", underrun, 0);

        // R9: restart in mid-frame
        set_cfg(0, 0, 0, 1, 0, 2, 0);
        slot(1, g, s2);
        for (int i = 0; i < 4; i++) slot(0, g, s2);
        run_frame(1, 1, "R9 restarted frame");
        check(fs_err == 1, "R9 fs_err set", fs_err, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check(fs_err == 0, "R10 fs_err cleared", fs_err, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule